// File: doc/BRIEF.md
# Paired-Page Translation Buffer

This block is a small, fully associative address translation buffer that software keeps filled. Each entry holds one virtual tag that covers a pair of adjacent 4 KB pages. Address bit 12 picks the even or the odd half, and each half has its own physical frame number, valid flag, dirty flag and a 3-bit cache attribute. Software loads an entry from three 32-bit words: a high word with the page tag and the address-space identifier, and two low words, one for each half. The entry is written either at an index that software supplies or at the value of a free-running down-counter. Any entry can be read back in the same word format.

The lookup port takes a 32-bit virtual address, a write flag and the current address-space identifier. One cycle later it reports a result code, the physical address and the read and write permissions. The result codes are hit, miss, invalid page and write to a clean page. The last three are for the exception logic, so that it can start a refill, a page-fault or a first-write handler.

Top module: `paired_tlb`

## Requirements
- R1: A write stores wr_hi[31:13] as the page tag and wr_hi[7:0] as the address-space identifier. wr_hi[12:8] is dropped and reads back as zero.
- R2: Each low word is decoded as global = bit 0, valid = bit 1, dirty = bit 2, attribute = bits 5:3 and frame number = bits 31:6. The entry's global flag is the AND of bit 0 of both low words.
- R3: With wr_random = 0, a write lands in entry (wr_index modulo NUM_ENTRIES).
- R4: With wr_random = 1, a write lands in the entry named by an internal counter. The counter is NUM_ENTRIES-1 after reset, drops by one on every clock and wraps from 0 back to NUM_ENTRIES-1.
- R5: Readback of entry (rd_index modulo NUM_ENTRIES) is combinational. rd_hi = {tag, 5'b0, asid}, and each rd_lo = {frame, attribute, dirty, valid, global}.
- R6: An entry matches when its tag equals lk_va[31:13] and either its global flag is set or its identifier equals lk_asid. If several entries match, the lowest index wins. If none matches, res_code = 1 (miss).
- R7: In the matching entry, lk_va[12] = 0 selects the even half (low word 0) and 1 selects the odd half (low word 1).
- R8: If the selected half is not valid, res_code = 2 (invalid), whatever lk_write is. Both permissions and res_pa are then zero.
- R9: A read, or a write to a dirty half, gives res_code = 0 (hit). res_pa = {frame, lk_va[11:0]}, res_perm_r = 1 and res_perm_w = dirty.
- R10: A write to a valid half that is not dirty gives res_code = 3 (modified). Both permissions and res_pa are then zero.
- R11: res_valid is lk_valid delayed by one clock, and the other result outputs are registered in the same cycle. A write in the same cycle as a lookup is not seen by that lookup, only by later ones.
- R12: A synchronous active-high rst zeroes every entry field, drops res_valid and sets the counter to NUM_ENTRIES-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write an entry at this edge |
| wr_random | input | 1 | 1: use the internal counter as index, 0: use wr_index |
| wr_index | input | IDX_REG_W | Index for indexed writes |
| wr_hi | input | 32 | Tag and identifier word |
| wr_lo0 | input | 32 | Even-half word |
| wr_lo1 | input | 32 | Odd-half word |
| rd_index | input | IDX_REG_W | Entry to read back |
| rd_hi | output | 32 | Rebuilt tag and identifier word |
| rd_lo0 | output | 32 | Rebuilt even-half word |
| rd_lo1 | output | 32 | Rebuilt odd-half word |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Virtual address |
| lk_write | input | 1 | Lookup is a store |
| lk_asid | input | 8 | Current address-space identifier |
| res_valid | output | 1 | Result valid, one cycle after the request |
| res_code | output | 2 | 0 hit, 1 miss, 2 invalid, 3 modified |
| res_pa | output | 38 | Physical address |
| res_perm_r | output | 1 | Read allowed |
| res_perm_w | output | 1 | Write allowed |

## Verification
The bench uses NUM_ENTRIES = 16 and IDX_REG_W = 8. The index port is therefore four bits wider than the entry index, so indexed writes with out-of-range values test the modulo folding. A 16-deep counter wraps several times during a few hundred cycles of random traffic, which brings random writes to every slot, including the wrap from 0 to 15. The bench also writes two entries with the same tag and puts writes in the same cycle as lookups, which covers the lowest-index rule and the one-cycle visibility rule.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;

    localparam int VA_W   = 32;
    localparam int EL_W   = 32;
    localparam int ASID_W = 8;
    localparam int OFFS_W = 12;
    localparam int VPN_W  = VA_W - OFFS_W - 1;
    localparam int PFN_W  = EL_W - 6;
    localparam int PA_W   = PFN_W + OFFS_W;
    localparam int GAP_W  = VA_W - VPN_W - ASID_W;

    typedef struct packed {
        logic             v;
        logic             d;
        logic [2:0]       attr;
        logic [PFN_W-1:0] pfn;
    } half_t;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic              glob;
        half_t             even;
        half_t             odd;
    } entry_t;

    typedef enum logic [1:0] {
        RES_HIT      = 2'd0,
        RES_MISS     = 2'd1,
        RES_INVALID  = 2'd2,
        RES_MODIFIED = 2'd3
    } res_e;

    function automatic logic [VA_W-1:0] hi_of(entry_t e);
        return {e.vpn, {GAP_W{1'b0}}, e.asid};
    endfunction

    function automatic logic [EL_W-1:0] lo_of(half_t h, logic g);
        return {h.pfn, h.attr, h.d, h.v, g};
    endfunction

endpackage

// File: rtl/ptlb_rand.sv
module ptlb_rand
    import ptlb_pkg::*;
#(
    parameter int N = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    output logic [$clog2(N)-1:0] rand_q
);
    localparam int IW = $clog2(N);
    localparam logic [IW-1:0] LAST = IW'(N - 1);

    always_ff @(posedge clk) begin
        if (rst)
            rand_q <= LAST;
        else if (rand_q == '0)
            rand_q <= LAST;
        else
            rand_q <= rand_q - 1'b1;
    end

    assert_rand_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (rand_q == '0) |=> (rand_q == LAST));
    assert_rand_step_R4: assert property (@(posedge clk) disable iff (rst)
        (rand_q != '0) |=> (rand_q == $past(rand_q) - 1'b1));

endmodule

// File: rtl/ptlb_store.sv
module ptlb_store
    import ptlb_pkg::*;
#(
    parameter int N = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [$clog2(N)-1:0] wr_idx,
    input  entry_t               wr_entry,
    output entry_t [N-1:0]       ent_q
);
    for (genvar i = 0; i < N; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                ent_q[i] <= '0;
            else if (wr_en && wr_idx == i)
                ent_q[i] <= wr_entry;
        end
    end

    assert_write_lands_R3: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ent_q[$past(wr_idx)] == $past(wr_entry)));

endmodule

// File: rtl/ptlb_match.sv
module ptlb_match
    import ptlb_pkg::*;
#(
    parameter int N = 16
) (
    input  entry_t [N-1:0]       ent,
    input  logic [VPN_W-1:0]     va_vpn,
    input  logic [ASID_W-1:0]    asid,
    output logic [N-1:0]         match_vec,
    output logic                 any_hit,
    output logic [$clog2(N)-1:0] hit_idx
);
    localparam int IW = $clog2(N);

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign match_vec[i] = (ent[i].vpn == va_vpn) &&
                              (ent[i].glob || ent[i].asid == asid);
    end

    assign any_hit = |match_vec;

    always_comb begin
        hit_idx = '0;
        for (int i = N - 1; i >= 0; i--)
            if (match_vec[i]) hit_idx = IW'(i);
    end

endmodule

// File: rtl/ptlb_resolve.sv
module ptlb_resolve
    import ptlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic              lk_write,
    input  logic [OFFS_W-1:0] lk_offs,
    input  logic              any_hit,
    input  logic              sel_v,
    input  logic              sel_d,
    input  logic [PFN_W-1:0]  sel_pfn,
    output logic              res_valid,
    output res_e              res_code,
    output logic [PA_W-1:0]   res_pa,
    output logic              res_perm_r,
    output logic              res_perm_w
);
    res_e            nx_code;
    logic [PA_W-1:0] nx_pa;
    logic            nx_r, nx_w;

    always_comb begin
        nx_code = RES_HIT;
        nx_pa   = '0;
        nx_r    = 1'b0;
        nx_w    = 1'b0;
        if (!any_hit)
            nx_code = RES_MISS;
        else if (!sel_v)
            nx_code = RES_INVALID;
        else if (lk_write && !sel_d)
            nx_code = RES_MODIFIED;
        else begin
            nx_pa = {sel_pfn, lk_offs};
            nx_r  = 1'b1;
            nx_w  = sel_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid  <= 1'b0;
            res_code   <= RES_HIT;
            res_pa     <= '0;
            res_perm_r <= 1'b0;
            res_perm_w <= 1'b0;
        end else begin
            res_valid <= lk_valid;
            if (lk_valid) begin
                res_code   <= nx_code;
                res_pa     <= nx_pa;
                res_perm_r <= nx_r;
                res_perm_w <= nx_w;
            end
        end
    end

    assert_result_follows_R11: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> res_valid);
    assert_no_spurious_result_R11: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !res_valid);
    assert_write_perm_only_on_hit_R9: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_perm_w) |-> (res_perm_r && res_code == RES_HIT));
    assert_read_never_modified_R10: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !lk_write) |=> (res_code != RES_MODIFIED));
    assert_invalid_no_perm_R8: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_code == RES_INVALID) |-> (!res_perm_r && !res_perm_w));

endmodule

// File: rtl/paired_tlb.sv
module paired_tlb
    import ptlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int IDX_REG_W   = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic                 wr_random,
    input  logic [IDX_REG_W-1:0] wr_index,
    input  logic [EL_W-1:0]      wr_hi,
    input  logic [EL_W-1:0]      wr_lo0,
    input  logic [EL_W-1:0]      wr_lo1,
    input  logic [IDX_REG_W-1:0] rd_index,
    output logic [EL_W-1:0]      rd_hi,
    output logic [EL_W-1:0]      rd_lo0,
    output logic [EL_W-1:0]      rd_lo1,
    input  logic                 lk_valid,
    input  logic [VA_W-1:0]      lk_va,
    input  logic                 lk_write,
    input  logic [ASID_W-1:0]    lk_asid,
    output logic                 res_valid,
    output logic [1:0]           res_code,
    output logic [PA_W-1:0]      res_pa,
    output logic                 res_perm_r,
    output logic                 res_perm_w
);
    localparam int IW = $clog2(NUM_ENTRIES);

    logic [IW-1:0]              rand_idx, wr_slot, rd_slot, hit_idx;
    entry_t                     wr_ent, rd_ent;
    entry_t [NUM_ENTRIES-1:0]   ent_q;
    logic [NUM_ENTRIES-1:0]     match_vec;
    logic                       any_hit, sel_v, sel_d;
    logic [PFN_W-1:0]           sel_pfn;
    res_e                       code_q;
    logic                       unused_hi_gap;

    assign unused_hi_gap = ^wr_hi[VA_W-VPN_W-1:ASID_W];

    assign wr_slot = wr_random ? rand_idx : IW'(wr_index % NUM_ENTRIES);
    assign rd_slot = IW'(rd_index % NUM_ENTRIES);

    always_comb begin
        wr_ent.vpn       = wr_hi[VA_W-1:VA_W-VPN_W];
        wr_ent.asid      = wr_hi[ASID_W-1:0];
        wr_ent.glob      = wr_lo0[0] & wr_lo1[0];
        wr_ent.even.v    = wr_lo0[1];
        wr_ent.even.d    = wr_lo0[2];
        wr_ent.even.attr = wr_lo0[5:3];
        wr_ent.even.pfn  = wr_lo0[EL_W-1:6];
        wr_ent.odd.v     = wr_lo1[1];
        wr_ent.odd.d     = wr_lo1[2];
        wr_ent.odd.attr  = wr_lo1[5:3];
        wr_ent.odd.pfn   = wr_lo1[EL_W-1:6];
    end

    ptlb_rand #(.N(NUM_ENTRIES)) u_rand (
        .clk    (clk),
        .rst    (rst),
        .rand_q (rand_idx)
    );

    ptlb_store #(.N(NUM_ENTRIES)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_idx   (wr_slot),
        .wr_entry (wr_ent),
        .ent_q    (ent_q)
    );

    ptlb_match #(.N(NUM_ENTRIES)) u_match (
        .ent       (ent_q),
        .va_vpn    (lk_va[VA_W-1:VA_W-VPN_W]),
        .asid      (lk_asid),
        .match_vec (match_vec),
        .any_hit   (any_hit),
        .hit_idx   (hit_idx)
    );

    always_comb begin
        if (lk_va[OFFS_W]) begin
            sel_v   = ent_q[hit_idx].odd.v;
            sel_d   = ent_q[hit_idx].odd.d;
            sel_pfn = ent_q[hit_idx].odd.pfn;
        end else begin
            sel_v   = ent_q[hit_idx].even.v;
            sel_d   = ent_q[hit_idx].even.d;
            sel_pfn = ent_q[hit_idx].even.pfn;
        end
    end

    ptlb_resolve u_resolve (
        .clk        (clk),
        .rst        (rst),
        .lk_valid   (lk_valid),
        .lk_write   (lk_write),
        .lk_offs    (lk_va[OFFS_W-1:0]),
        .any_hit    (any_hit),
        .sel_v      (sel_v),
        .sel_d      (sel_d),
        .sel_pfn    (sel_pfn),
        .res_valid  (res_valid),
        .res_code   (code_q),
        .res_pa     (res_pa),
        .res_perm_r (res_perm_r),
        .res_perm_w (res_perm_w)
    );

    assign res_code = code_q;

    assign rd_ent = ent_q[rd_slot];
    assign rd_hi  = hi_of(rd_ent);
    assign rd_lo0 = lo_of(rd_ent.even, rd_ent.glob);
    assign rd_lo1 = lo_of(rd_ent.odd, rd_ent.glob);

    assert_pick_is_match_R6: assert property (@(posedge clk) disable iff (rst)
        any_hit |-> match_vec[hit_idx]);
    assert_pick_is_lowest_R6: assert property (@(posedge clk) disable iff (rst)
        any_hit |-> ((match_vec & ((NUM_ENTRIES'(1) << hit_idx) - 1'b1)) == '0));

endmodule

// File: tb/test_paired_tlb.sv
module test_paired_tlb;
    import ptlb_pkg::*;

    localparam int N  = 16;
    localparam int XW = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst = 1'b1, wr_en = 0, wr_random = 0, lk_valid = 0, lk_write = 0;
    logic [XW-1:0] wr_index = '0, rd_index = '0;
    logic [31:0] wr_hi = '0, wr_lo0 = '0, wr_lo1 = '0, lk_va = '0;
    logic [7:0] lk_asid = '0;
    logic [31:0] rd_hi, rd_lo0, rd_lo1;
    logic res_valid, res_perm_r, res_perm_w;
    logic [1:0] res_code;
    logic [PA_W-1:0] res_pa;

    paired_tlb #(.NUM_ENTRIES(N), .IDX_REG_W(XW)) i_paired_tlb (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_random(wr_random),
        .wr_index(wr_index), .wr_hi(wr_hi), .wr_lo0(wr_lo0), .wr_lo1(wr_lo1),
        .rd_index(rd_index), .rd_hi(rd_hi), .rd_lo0(rd_lo0), .rd_lo1(rd_lo1),
        .lk_valid(lk_valid), .lk_va(lk_va), .lk_write(lk_write), .lk_asid(lk_asid),
        .res_valid(res_valid), .res_code(res_code), .res_pa(res_pa),
        .res_perm_r(res_perm_r), .res_perm_w(res_perm_w)
    );

    int n_checks = 0, n_fail = 0;
    bit finished = 0;

    logic [31:0] m_hi [N], m_lo0 [N], m_lo1 [N];
    int m_rand = N - 1;
    int last_slot = 0;

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(string req);
        bit ev;
        int hit;
        logic [31:0] lo;
        logic [1:0] e_code;
        logic [PA_W-1:0] e_pa;
        bit e_r, e_w;
        ev = lk_valid && !rst;
        hit = -1;
        for (int i = N - 1; i >= 0; i--)
            if (m_hi[i][31:13] == lk_va[31:13] &&
                ((m_lo0[i][0] == 1'b1) || m_hi[i][7:0] == lk_asid)) hit = i;
        e_code = 2'd1; e_pa = '0; e_r = 0; e_w = 0;
        if (hit >= 0) begin
            lo = lk_va[12] ? m_lo1[hit] : m_lo0[hit];
            if (!lo[1]) e_code = 2'd2;
            else if (lk_write && !lo[2]) e_code = 2'd3;
            else begin
                e_code = 2'd0; e_pa = {lo[31:6], lk_va[11:0]}; e_r = 1; e_w = lo[2];
            end
        end
        if (!rst && wr_en) begin
            int s;
            logic g;
            s = wr_random ? m_rand : int'(wr_index) % N;
            last_slot = s;
            g = wr_lo0[0] & wr_lo1[0];
            m_hi[s]  = wr_hi & 32'hFFFFE0FF;
            m_lo0[s] = {wr_lo0[31:1], g};
            m_lo1[s] = {wr_lo1[31:1], g};
        end
        @(posedge clk);
        if (rst) begin
            for (int i = 0; i < N; i++) begin m_hi[i] = '0; m_lo0[i] = '0; m_lo1[i] = '0; end
            m_rand = N - 1;
        end else m_rand = (m_rand == 0) ? N - 1 : m_rand - 1;
        @(negedge clk);
        check(res_valid == ev, "R11", "res_valid", 64'(res_valid), 64'(ev));
        if (ev) begin
            check(res_code == e_code, req, "res_code", 64'(res_code), 64'(e_code));
            check(res_pa == e_pa, req, "res_pa", 64'(res_pa), 64'(e_pa));
            check(res_perm_r == e_r && res_perm_w == e_w, req, "perms",
                  64'({res_perm_r, res_perm_w}), 64'({e_r, e_w}));
        end
    endtask

    task automatic readback(int idx, string req);
        int s;
        rd_index = XW'(idx);
        s = idx % N;
        #1;
        check(rd_hi == m_hi[s], req, "rd_hi", 64'(rd_hi), 64'(m_hi[s]));
        check(rd_lo0 == m_lo0[s], req, "rd_lo0", 64'(rd_lo0), 64'(m_lo0[s]));
        check(rd_lo1 == m_lo1[s], req, "rd_lo1", 64'(rd_lo1), 64'(m_lo1[s]));
    endtask

    task automatic look(logic [31:0] va, bit wr, logic [7:0] asid, string req);
        lk_valid = 1; lk_va = va; lk_write = wr; lk_asid = asid;
        tick(req);
        lk_valid = 0;
    endtask

    task automatic write_at(bit rnd, int idx, logic [31:0] hi, logic [31:0] l0, logic [31:0] l1);
        wr_en = 1; wr_random = rnd; wr_index = XW'(idx); wr_hi = hi; wr_lo0 = l0; wr_lo1 = l1;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL R11 watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    localparam logic [31:0] HI_A = 32'h12345F42;
    localparam logic [31:0] HI_B = 32'h0ABC2042;
    localparam logic [31:0] HI_C = 32'h70000007;

    initial begin
        int unsigned seed;
        logic [31:0] pool [3];
        for (int i = 0; i < N; i++) begin m_hi[i] = 'x; m_lo0[i] = 'x; m_lo1[i] = 'x; end
        pool[0] = HI_A; pool[1] = HI_B; pool[2] = HI_C;
        @(negedge clk);
        // R12: reset clears all entries and the result
        repeat (3) tick("R12");
        rst = 0;
        readback(0, "R12");
        readback(15, "R12");

        // R1 R2 R3: indexed write, index 0x23 folds to 3; global set in both words
        write_at(0, 8'h23, HI_A, {26'h2AAAA, 3'd5, 3'b111}, {26'h1555, 3'd2, 3'b011});
        tick("R3");
        wr_en = 0;
        readback(3, "R1");
        check(rd_hi[12:8] == 5'd0, "R1", "hi gap", 64'(rd_hi[12:8]), 64'd0);
        check(rd_lo0[5:3] == 3'd5 && rd_lo0[0], "R2", "lo0 attr/g", 64'(rd_lo0[5:0]), 64'h2F);
        readback(8'h23, "R5");

        // R9 R7: even-half read, other identifier but global
        look({HI_A[31:13], 1'b0, 12'hABC}, 0, 8'h99, "R9");
        look({HI_A[31:13], 1'b0, 12'h123}, 1, 8'h99, "R9");
        // R10: write to clean odd half
        look({HI_A[31:13], 1'b1, 12'h456}, 1, 8'h42, "R10");
        // R7: odd read gives odd frame, no write permission
        look({HI_A[31:13], 1'b1, 12'h456}, 0, 8'h42, "R7");

        // Entry 5, not global (bit 0 only in lo0), even half invalid
        write_at(0, 5, HI_B, {26'h0BEEF, 3'd1, 3'b101}, {26'h3C0DE, 3'd0, 3'b110});
        tick("R2");
        wr_en = 0;
        readback(5, "R2");
        look({HI_B[31:13], 1'b1, 12'h010}, 0, 8'h43, "R6");
        look({HI_B[31:13], 1'b0, 12'h010}, 1, 8'h42, "R8");
        look({HI_B[31:13], 1'b0, 12'h010}, 0, 8'h42, "R8");
        look({HI_B[31:13], 1'b1, 12'hFFF}, 1, 8'h42, "R9");

        // R6: duplicate tag at slot 7, lowest index (3) must win
        write_at(0, 7, HI_A, {26'h0F0F0, 3'd0, 3'b111}, {26'h0F0F1, 3'd0, 3'b111});
        tick("R3");
        wr_en = 0;
        look({HI_A[31:13], 1'b0, 12'h777}, 0, 8'h00, "R6");

        // R11 R4: random write in the same cycle as a lookup of its tag
        write_at(1, 0, HI_C, {26'h11111, 3'd3, 3'b110}, {26'h22222, 3'd3, 3'b110});
        lk_valid = 1; lk_va = {HI_C[31:13], 1'b0, 12'h001}; lk_write = 0; lk_asid = 8'h07;
        tick("R11");
        wr_en = 0; wr_random = 0;
        look({HI_C[31:13], 1'b0, 12'h001}, 0, 8'h07, "R11");
        readback(last_slot, "R4");

        // R4 R6 R8 R9 R10: random traffic
        seed = 32'h1234567;
        for (int k = 0; k < 400; k++) begin
            int unsigned r;
            seed = seed * 1103515245 + 12345; r = seed >> 8;
            wr_en = (r[2:0] == 3'd0);
            wr_random = r[3];
            wr_index = XW'(r[11:4]);
            wr_hi = pool[r[13:12] % 3] ^ {19'd0, 5'(r[18:14]), 8'd0};
            seed = seed * 1103515245 + 12345; wr_lo0 = seed;
            seed = seed * 1103515245 + 12345; wr_lo1 = seed;
            seed = seed * 1103515245 + 12345; r = seed >> 8;
            lk_valid = (r[1:0] != 2'd0);
            lk_va = {pool[r[3:2] % 3][31:13], 13'(r[16:4])};
            lk_write = r[17];
            lk_asid = r[18] ? 8'h42 : 8'h07;
            tick("R4");
            if (wr_en) begin wr_en = 0; readback(last_slot, "R4"); end
        end
        lk_valid = 0; wr_en = 0;
        for (int i = 0; i < N; i++) readback(i, "R5");

        // R12: reset again, all cleared
        rst = 1;
        tick("R12");
        rst = 0;
        readback(3, "R12");
        finished = 1;
        summary();
        $finish;
    end

endmodule